// File: doc/BRIEF.md
# Automatic Xoff/Xon Transmit Injector

This block sits in front of the serial transmitter of a UART. It watches the receive FIFO fill level and compares it against a programmed trigger level. When the level reaches the trigger, the block asks the transmitter to send the Xoff code, so that the remote side pauses. In single mode the Xoff code is one character. In double mode it is two characters. When the level later drops back below the trigger, the block sends the Xon code in the same way, and the remote side resumes. There is no hysteresis: one comparison against the trigger drives both directions.

Normal transmit FIFO data and injected control characters share one valid/ready stream into the serializer. The serializer raises `tx_ready` only when it can take a new character. A character is handed over on any cycle where `tx_valid` and `tx_ready` are both high, so a character already being shifted out is never cut short. While a control character is pending it owns the stream, and `fifo_ready` is held low to apply back-pressure to the transmit FIFO.

An offered control byte holds its value until it is accepted. There is one exception: a pending first Xoff character is withdrawn if the fill level falls or the enable is cleared before the serializer accepts it. The offered code is masked to the programmed word length.

Top module: `fctl_tx_inject`

## Requirements
- R1: When no control character is pending, the transmit FIFO stream passes straight through: `tx_valid`=`fifo_valid`, `tx_data`=`fifo_data` and `fifo_ready`=`tx_ready`. Reset leaves the block in this state.
- R2: With `auto_en`=1 and no sequence in progress, a fill level greater than or equal to `trig_level` puts the first Xoff code on `tx_data`, with `tx_valid`=1, one clock later.
- R3: When `dual_mode`=1, acceptance of the first Xoff (Xon) character is followed on the next cycle by the second Xoff (Xon) character. When `dual_mode`=0, the sequence ends after the first character.
- R4: After the Xoff sequence has been accepted, no further control character is offered while the level stays at or above the trigger, whatever the level does within that range.
- R5: After the Xoff sequence has been accepted, a level below `trig_level` (with `auto_en`=1) offers the first Xon code one clock later. Once the Xon sequence is accepted, the block is re-armed for the next crossing.
- R6: The control code is masked to the word length. `wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, taken from bit 0 upward. Code bits above the selected length read as zero on `tx_data`.
- R7: While a control character is offered, `fifo_ready` is 0 and `tx_data` carries the control code regardless of `fifo_valid`. The offer holds until `tx_ready` is seen.
- R8: If the level falls below the trigger, or `auto_en` is cleared, before the first Xoff character is accepted, the offer is withdrawn on the next cycle. Nothing is sent, and no Xon follows.
- R9: Clearing `auto_en` after the Xoff sequence returns the block to idle without sending Xon.
- R10: With `auto_en`=0, no control character is ever offered, regardless of the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_en | input | 1 | Enables automatic Xoff/Xon sending |
| dual_mode | input | 1 | 1 = two-character codes, 0 = one character |
| wlen | input | 2 | Word length select: 0..3 gives 5..8 bits |
| rx_level | input | CNT_W | Receive FIFO fill level |
| trig_level | input | CNT_W | Trigger level |
| xoff_code1 | input | 8 | First Xoff character |
| xoff_code2 | input | 8 | Second Xoff character |
| xon_code1 | input | 8 | First Xon character |
| xon_code2 | input | 8 | Second Xon character |
| fifo_data | input | 8 | Transmit FIFO data |
| fifo_valid | input | 1 | Transmit FIFO has data |
| fifo_ready | output | 1 | Transmit FIFO byte taken this cycle |
| tx_data | output | 8 | Character to serializer |
| tx_valid | output | 1 | Character offered to serializer |
| tx_ready | input | 1 | Serializer takes a character |

## Verification
The bench builds the block with `CNT_W`=4, which makes 16 fill levels. This small width allows every trigger value from 1 to 15 to be paired with every level from 0 to 15 in a single-mode round trip (Xoff, then Xon), with the expected decision computed as level >= trigger. The same build covers all four word lengths for the masking check. It also reaches the corner cases directly: stalls from `tx_ready`, a pending Xoff that is withdrawn, a disable after Xoff, and double-mode sequences.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFF1,
    ST_OFF2,
    ST_OFF_DONE,
    ST_ON1,
    ST_ON2
  } fctl_state_e;

  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wl);
    case (wl)
      2'd0:    len_mask = 8'h1F;
      2'd1:    len_mask = 8'h3F;
      2'd2:    len_mask = 8'h7F;
      default: len_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/fctl_level_cmp.sv
module fctl_level_cmp #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] trig,
  output logic             above
);
  always_comb above = (level >= trig);
endmodule

// File: rtl/fctl_seq_fsm.sv
module fctl_seq_fsm
  import fctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dual,
  input  logic              above,
  input  logic              tx_ready,
  input  logic [CHAR_W-1:0] off1,
  input  logic [CHAR_W-1:0] off2,
  input  logic [CHAR_W-1:0] on1,
  input  logic [CHAR_W-1:0] on2,
  output logic              ctl_valid,
  output logic [CHAR_W-1:0] ctl_code
);
  fctl_state_e st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:     if (en && above) st_nx = ST_OFF1;
      ST_OFF1: begin
        if (tx_ready)             st_nx = dual ? ST_OFF2 : ST_OFF_DONE;
        else if (!above || !en)   st_nx = ST_IDLE;
      end
      ST_OFF2:     if (tx_ready) st_nx = ST_OFF_DONE;
      ST_OFF_DONE: begin
        if (!en)         st_nx = ST_IDLE;
        else if (!above) st_nx = ST_ON1;
      end
      ST_ON1:      if (tx_ready) st_nx = dual ? ST_ON2 : ST_IDLE;
      ST_ON2:      if (tx_ready) st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl_valid = 1'b1;
    ctl_code  = '0;
    case (st)
      ST_OFF1: ctl_code = off1;
      ST_OFF2: ctl_code = off2;
      ST_ON1:  ctl_code = on1;
      ST_ON2:  ctl_code = on2;
      default: ctl_valid = 1'b0;
    endcase
  end

  // R2
  off_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && en && above) |=> (st == ST_OFF1));
  // R3
  off_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF1 && tx_ready && dual) |=> (st == ST_OFF2));
  // R4
  off_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF_DONE && en && above) |=> (st == ST_OFF_DONE));
  // R5
  on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF_DONE && en && !above) |=> (st == ST_ON1));
  // R8
  off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF1 && !above && !tx_ready) |=> (st == ST_IDLE));
  // R9
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF_DONE && !en) |=> (st == ST_IDLE));
  // R10
  no_ctl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !en) |=> !ctl_valid);
endmodule

// File: rtl/fctl_tx_mux.sv
module fctl_tx_mux
  import fctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic [CHAR_W-1:0] ctl_code,
  input  logic [1:0]        wlen,
  input  logic [CHAR_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  logic [CHAR_W-1:0] mask;

  always_comb begin
    mask = len_mask(wlen);
    if (ctl_valid) begin
      tx_valid   = 1'b1;
      tx_data    = ctl_code & mask;
      fifo_ready = 1'b0;
    end else begin
      tx_valid   = fifo_valid;
      tx_data    = fifo_data;
      fifo_ready = tx_ready;
    end
  end

  // R7
  ctl_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> (!fifo_ready && tx_valid));
  // R7
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !tx_ready && $stable(wlen)) |=> (!ctl_valid || $stable(tx_data) || !$stable(ctl_code)));
  // R6
  ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> ((tx_data & ~len_mask(wlen)) == '0));
endmodule

// File: rtl/fctl_tx_inject.sv
module fctl_tx_inject
  import fctl_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              dual_mode,
  input  logic [1:0]        wlen,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  trig_level,
  input  logic [CHAR_W-1:0] xoff_code1,
  input  logic [CHAR_W-1:0] xoff_code2,
  input  logic [CHAR_W-1:0] xon_code1,
  input  logic [CHAR_W-1:0] xon_code2,
  input  logic [CHAR_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  logic              above;
  logic              ctl_valid;
  logic [CHAR_W-1:0] ctl_code;

  fctl_level_cmp #(.CNT_W(CNT_W)) u_cmp (
    .level (rx_level),
    .trig  (trig_level),
    .above (above)
  );

  fctl_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (auto_en),
    .dual      (dual_mode),
    .above     (above),
    .tx_ready  (tx_ready),
    .off1      (xoff_code1),
    .off2      (xoff_code2),
    .on1       (xon_code1),
    .on2       (xon_code2),
    .ctl_valid (ctl_valid),
    .ctl_code  (ctl_code)
  );

  fctl_tx_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_valid  (ctl_valid),
    .ctl_code   (ctl_code),
    .wlen       (wlen),
    .fifo_data  (fifo_data),
    .fifo_valid (fifo_valid),
    .fifo_ready (fifo_ready),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready)
  );
endmodule

// File: tb/fctl_tx_inject_tb.sv
`timescale 1ns/1ps
module fctl_tx_inject_tb;
  localparam int CW = 4;
  localparam logic [7:0] OFF1 = 8'hD3, OFF2 = 8'h93, ON1 = 8'hF1, ON2 = 8'hB9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, dual_mode = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic [CW-1:0] rx_level = '0, trig_level = '0;
  logic [7:0] fifo_data = '0;
  logic fifo_valid = 1'b0, tx_ready = 1'b0;
  logic fifo_ready, tx_valid;
  logic [7:0] tx_data;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  fctl_tx_inject #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .dual_mode(dual_mode),
    .wlen(wlen), .rx_level(rx_level), .trig_level(trig_level),
    .xoff_code1(OFF1), .xoff_code2(OFF2), .xon_code1(ON1), .xon_code2(ON2),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [1:0] w);
    return 8'((1 << (5 + w)) - 1);
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state: pass-through
    fifo_valid = 1'b1; fifo_data = 8'hA5; tx_ready = 1'b1;
    #1;
    check("R1 valid", tx_valid, 1);
    check("R1 data", tx_data, 8'hA5);
    check("R1 ready", fifo_ready, 1);
    rst_n = 1'b1;
    tick();
    fifo_valid = 1'b0; tx_ready = 1'b0;
    tick();
    check("R1 ready low", fifo_ready, 0);
    check("R1 valid low", tx_valid, 0);

    // R10 disabled: nothing injected
    auto_en = 1'b0; trig_level = 4; rx_level = 15; tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R10 idle", tx_valid, 0);
    end
    rx_level = 0;
    tick();

    // R2/R5 sweep in single mode
    auto_en = 1'b1;
    for (int t = 1; t < 16; t++) begin
      for (int l = 0; l < 16; l++) begin
        trig_level = CW'(t); rx_level = '0;
        tick();
        rx_level = CW'(l);
        tick();
        check("R2 offer", tx_valid, int'(l >= t));
        if (l >= t) check("R2 code", tx_data, OFF1);
        tick();
        check("R3 single end", tx_valid, 0);
        rx_level = '0;
        tick();
        check("R5 xon", tx_valid, int'(l >= t));
        if (l >= t) check("R5 code", tx_data, ON1);
        tick();
        check("R5 rearm", tx_valid, 0);
      end
    end

    // R3 dual mode sequences
    dual_mode = 1'b1; trig_level = 8; rx_level = 10;
    tick(); check("R3 off1", tx_data, OFF1);
    tick(); check("R3 off2", tx_data, OFF2); check("R3 off2 valid", tx_valid, 1);
    tick(); check("R3 off end", tx_valid, 0);
    rx_level = 3;
    tick(); check("R3 on1", tx_data, ON1);
    tick(); check("R3 on2", tx_data, ON2); check("R3 on2 valid", tx_valid, 1);
    tick(); check("R3 on end", tx_valid, 0);
    dual_mode = 1'b0;

    // R7 priority and stall
    tx_ready = 1'b0; fifo_valid = 1'b1; fifo_data = 8'h5A; rx_level = 10;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R7 code held", tx_data, OFF1);
      check("R7 fifo blocked", fifo_ready, 0);
    end
    tx_ready = 1'b1;
    tick();
    check("R1 after xoff", tx_data, 8'h5A);
    check("R1 fifo ready", fifo_ready, 1);
    // R4 no repeat while above
    for (int l = 8; l < 16; l++) begin
      rx_level = CW'(l);
      tick();
      check("R4 no repeat", tx_data, 8'h5A);
    end
    rx_level = 0; fifo_valid = 1'b0;
    tick(); check("R5 xon after hold", tx_data, ON1);
    tick(); check("R5 idle", tx_valid, 0);

    // R8 withdrawn Xoff
    tx_ready = 1'b0; rx_level = 12;
    tick(); check("R8 offered", tx_valid, 1);
    rx_level = 2;
    tick(); check("R8 withdrawn", tx_valid, 0);
    tx_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R8 no xon", tx_valid, 0);
    end
    tx_ready = 1'b0; rx_level = 12;
    tick(); check("R8 offered again", tx_valid, 1);
    auto_en = 1'b0;
    tick(); check("R8 disable withdraw", tx_valid, 0);
    auto_en = 1'b1; rx_level = 0; tx_ready = 1'b1;
    tick();

    // R9 disable after Xoff
    rx_level = 12;
    tick(); check("R9 off1", tx_data, OFF1);
    tick(); check("R9 sent", tx_valid, 0);
    auto_en = 1'b0;
    tick(); check("R9 disabled", tx_valid, 0);
    rx_level = 0;
    tick(); check("R9 no xon", tx_valid, 0);
    auto_en = 1'b1;
    tick(); check("R9 still idle", tx_valid, 0);
    tick(); check("R9 still idle 2", tx_valid, 0);

    // R6 word length masking
    for (int w = 0; w < 4; w++) begin
      wlen = 2'(w); rx_level = 0; tx_ready = 1'b0;
      tick();
      rx_level = 15;
      tick(); check("R6 xoff mask", tx_data, OFF1 & mk(2'(w)));
      tx_ready = 1'b1;
      tick();
      rx_level = 0;
      tick(); check("R6 xon mask", tx_data, ON1 & mk(2'(w)));
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule